// File: doc/BRIEF.md
# Serial-Bus Controlled Clock Fanout Enable

This block lets a system controller switch each of the eighteen copies of a buffered clock on or off. It does this through a two-wire serial slave port on SCL and SDA, where SDA is open-drain. A faster system clock oversamples both bus lines. Start and stop conditions, bit timing and acknowledge slots are all recovered from those samples. The slave uses a block-transfer protocol, so every transfer walks the register bytes from index 0 upward.

In a write, the master sends the address byte, then two bytes that are acknowledged and thrown away (a command byte and a length byte), then the enable bytes. In a read, the slave first returns a length byte, then the enable bytes, then 0xFF for as long as the master keeps reading.

Each enable bit gates its output on a falling edge of the reference clock, so a switched output never produces a shortened pulse. A global active-low output-enable input drops the drive enable of every output at once, whatever the register bits hold.

Top module: `fanout_enable_ctrl`

## Requirements
- R1: After reset, all enable bits are 1. Every output follows the reference clock, every drive enable is 1 while oe_n is high, and SDA is released.
- R2: The slave acknowledges only the 7-bit address 7'h69 (0xD2 = write, 0xD3 = read). Any other address gets no acknowledge, and the slave stays silent until the next start.
- R3: In a write, the slave acknowledges every byte. The first two bytes after the address are discarded. The bytes that follow load enable byte 0 (outputs 0-7, bit n = output n), then byte 1 (outputs 8-15, bit n = output 8+n), then byte 2. A 1 enables an output.
- R4: In byte 2, bit 6 controls output 16 and bit 7 controls output 17. Bits 0-5 always read back as 1, whatever was written.
- R5: Bytes written after byte 2 are acknowledged and change nothing.
- R6: A read returns 0x09 first, then bytes 0, 1 and 2, then 0xFF for every further byte.
- R7: When the master does not acknowledge a read byte, the transfer ends. SDA stays released until the next start.
- R8: A stop inside a byte abandons the transfer and leaves the registers unchanged. A start at any point begins a new address phase.
- R9: A disabled output is held low. An enable change takes effect only while the reference clock is low, so no output pulse is ever shortened.
- R10: While oe_n is low, every output drive enable is 0. While oe_n is high, every drive enable is 1. The register contents are not affected by oe_n.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| ref_clk | input | 1 | Buffered clock to be fanned out |
| oe_n | input | 1 | Global active-low output drive enable |
| clk_out | output | 18 | Gated copies of ref_clk |
| clk_out_en | output | 18 | Per-output drive enable; 0 means high impedance |

## Verification
Writes use distinct patterns so that each byte lane shows up separately on the outputs and in readback. One pattern sets only bit 7 of byte 2, which tells output 16 apart from output 17. All-zero and all-one patterns show that switching never shortens a reference-clock pulse. Longer writes and longer reads show that data past the last register is discarded on write and reads back as 0xFF. Wrong addresses, a stop inside a byte, a repeated start and a master NACK show that only complete, addressed bytes change state, and that the slave then releases the bus.

// File: rtl/fo_pkg.sv
package fo_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } fo_state_t;
endpackage

// File: rtl/fo_bus_sampler.sv
module fo_bus_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_s, scl_d, sda_d;

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_s <= 1'b1;
            sda_s <= 1'b1;
         end else begin
            scl_s <= scl_i;
            sda_s <= sda_i;
         end
      end
   end else begin : g_chain
      logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
         end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         end
      end
      assign scl_s = scl_sh[SYNC_STAGES-1];
      assign sda_s = sda_sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/fo_i2c_engine.sv
module fo_i2c_engine
   import fo_pkg::*;
#(
   parameter int          NUM_OUT    = 18,
   parameter logic [6:0]  DEV_ADDR   = 7'h69,
   parameter logic [7:0]  BYTE_COUNT = 8'h09,
   parameter int          SKIP_BYTES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   output logic               sda_oe,
   output logic [NUM_OUT-1:0] en_bits
);
   localparam int         NREG    = (NUM_OUT + 7) / 8;
   localparam int         TAIL    = NUM_OUT - 8 * (NREG - 1);
   localparam logic [7:0] RESV    = 8'(8'hFF >> TAIL);
   localparam int         IDX_MAX = SKIP_BYTES + NREG + 2;
   localparam int         IDXW    = $clog2(IDX_MAX + 1);

   fo_state_t       state;
   logic [3:0]      bit_cnt;
   logic [7:0]      shreg, txsr, rd_data;
   logic            is_addr, rd_mode, mack_ok;
   logic [IDXW-1:0] idx, idx_next;
   logic [7:0]      regs [NREG];

   assign idx_next = (idx == IDXW'(IDX_MAX)) ? idx : idx + 1'b1;

   always_comb begin
      rd_data = 8'hFF;
      if (idx == '0) rd_data = BYTE_COUNT;
      for (int k = 0; k < NREG; k++)
         if (idx == IDXW'(k + 1)) rd_data = regs[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         txsr    <= '1;
         is_addr <= 1'b0;
         rd_mode <= 1'b0;
         mack_ok <= 1'b0;
         idx     <= '0;
         for (int k = 0; k < NREG; k++) regs[k] <= 8'hFF;
      end else if (start_det) begin
         state   <= ST_RX;
         is_addr <= 1'b1;
         rd_mode <= 1'b0;
         bit_cnt <= '0;
         idx     <= '0;
      end else if (stop_det) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg   <= {shreg[6:0], sda_s};
                  bit_cnt <= bit_cnt + 1'b1;
               end else if (scl_fall && bit_cnt == 4'd8) begin
                  bit_cnt <= '0;
                  if (is_addr) begin
                     if (shreg[7:1] == DEV_ADDR) begin
                        state   <= ST_ACK;
                        rd_mode <= shreg[0];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else begin
                     state <= ST_ACK;
                     for (int k = 0; k < NREG; k++)
                        if (idx == IDXW'(SKIP_BYTES + k))
                           regs[k] <= shreg | ((k == NREG - 1) ? RESV : 8'h00);
                     idx <= idx_next;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  is_addr <= 1'b0;
                  bit_cnt <= '0;
                  if (rd_mode) begin
                     state <= ST_TX;
                     txsr  <= rd_data;
                     idx   <= idx_next;
                  end else begin
                     state <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     state   <= ST_MACK;
                     bit_cnt <= '0;
                  end else begin
                     txsr    <= {txsr[6:0], 1'b1};
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  mack_ok <= ~sda_s;
               end else if (scl_fall) begin
                  if (mack_ok) begin
                     state <= ST_TX;
                     txsr  <= rd_data;
                     idx   <= idx_next;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_oe = (state == ST_ACK) | ((state == ST_TX) & ~txsr[7]);

   for (genvar k = 0; k < NREG - 1; k++) begin : g_full
      assign en_bits[8*k +: 8] = regs[k];
   end
   assign en_bits[NUM_OUT-1 -: TAIL] = regs[NREG-1][7 -: TAIL];
endmodule

// File: rtl/fo_out_gate.sv
module fo_out_gate #(
   parameter int NUM_OUT = 18
) (
   input  logic               rst_n,
   input  logic               ref_clk,
   input  logic               oe_n,
   input  logic [NUM_OUT-1:0] en_bits,
   output logic [NUM_OUT-1:0] clk_out,
   output logic [NUM_OUT-1:0] clk_out_en
);
   for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
      logic gate_q;
      always_ff @(negedge ref_clk or negedge rst_n) begin
         if (!rst_n) gate_q <= 1'b1;
         else        gate_q <= en_bits[i];
      end
      assign clk_out[i]    = ref_clk & gate_q;
      assign clk_out_en[i] = oe_n;
   end
endmodule

// File: rtl/fanout_enable_ctrl.sv
module fanout_enable_ctrl #(
   parameter int          NUM_OUT     = 18,
   parameter logic [6:0]  DEV_ADDR    = 7'h69,
   parameter logic [7:0]  BYTE_COUNT  = 8'h09,
   parameter int          SKIP_BYTES  = 2,
   parameter int          SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic               ref_clk,
   input  logic               oe_n,
   output logic [NUM_OUT-1:0] clk_out,
   output logic [NUM_OUT-1:0] clk_out_en
);
   if (NUM_OUT < 9 || NUM_OUT > 64) begin : g_bad_num
      $error("NUM_OUT must lie between 9 and 64");
   end
   if (SKIP_BYTES < 0 || SKIP_BYTES > 8) begin : g_bad_skip
      $error("SKIP_BYTES must lie between 0 and 8");
   end

   logic sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [NUM_OUT-1:0] en_bits;

   fo_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   fo_i2c_engine #(
      .NUM_OUT(NUM_OUT), .DEV_ADDR(DEV_ADDR),
      .BYTE_COUNT(BYTE_COUNT), .SKIP_BYTES(SKIP_BYTES)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .sda_oe(sda_oe), .en_bits(en_bits)
   );

   fo_out_gate #(.NUM_OUT(NUM_OUT)) u_gate (
      .rst_n(rst_n), .ref_clk(ref_clk), .oe_n(oe_n), .en_bits(en_bits),
      .clk_out(clk_out), .clk_out_en(clk_out_en)
   );
endmodule

// File: rtl/fo_checker.sv
module fo_checker #(
   parameter int NUM_OUT = 18
) (
   input logic               clk,
   input logic               rst_n,
   input logic               scl_i,
   input logic               scl_fall,
   input logic               start_det,
   input logic               stop_det,
   input logic               sda_oe,
   input logic               oe_n,
   input logic [NUM_OUT-1:0] clk_out_en,
   input logic [NUM_OUT-1:0] en_bits
);
   AST_EN_ON_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (en_bits != $past(en_bits)) |-> $past(scl_fall)); // R3

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R8

   AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe); // R8

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_i); // R11

   AST_OE_FLOATS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (clk_out_en == '0)); // R10
endmodule

bind fanout_enable_ctrl fo_checker #(.NUM_OUT(NUM_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_fall(scl_fall),
   .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe),
   .oe_n(oe_n), .clk_out_en(clk_out_en), .en_bits(en_bits)
);

// File: tb/fanout_enable_ctrl_tb.sv
module fanout_enable_ctrl_tb;
   localparam int Q = 15;

   logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
   logic scl = 1'b1, m_low = 1'b0, oe_n = 1'b1;
   logic sda_oe, sda_bus;
   logic [17:0] clk_out, clk_out_en;
   int nchk = 0, nfail = 0, runt = 0;
   bit done = 1'b0;
   logic [7:0] model [3];

   assign sda_bus = ~(m_low | sda_oe);

   always #10 clk = ~clk;
   always #15 ref_clk = ~ref_clk;

   fanout_enable_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
      .ref_clk(ref_clk), .oe_n(oe_n), .clk_out(clk_out), .clk_out_en(clk_out_en)
   );

   logic [17:0] prev_out = '0;
   always @(clk_out) begin
      for (int i = 0; i < 18; i++) begin
         if (prev_out[i] === 1'b1 && clk_out[i] === 1'b0 && ref_clk !== 1'b0) runt++;
         if (prev_out[i] === 1'b0 && clk_out[i] === 1'b1 && ref_clk !== 1'b1) runt++;
      end
      prev_out = clk_out;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; w(Q); scl = 1'b1; w(Q); m_low = 1'b1; w(Q); scl = 1'b0; w(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; w(Q); scl = 1'b1; w(Q); m_low = 1'b0; w(Q);
   endtask

   task automatic bit_x(input logic b, output logic seen);
      m_low = ~b; w(Q); scl = 1'b1; w(Q); seen = sda_bus; w(Q); scl = 1'b0; w(Q);
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_x(d[i], s);
      bit_x(1'b1, s);
      ack = ~s;
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_x(1'b1, s);
         d[i] = s;
      end
      bit_x(~mack, s);
   endtask

   function automatic logic [7:0] exp_rd(input int i);
      if (i == 0) return 8'h09;
      if (i == 3) return model[2] | 8'h3F;
      if (i >= 1 && i <= 2) return model[i-1];
      return 8'hFF;
   endfunction

   function automatic logic [17:0] exp_en();
      return {model[2][7:6], model[1], model[0]};
   endfunction

   task automatic write_seq(input logic [7:0] d [8], input int len, input string req);
      logic ack;
      bus_start();
      wr_byte(8'hD2, ack);
      chk(ack, "R2", "write address ack", ack, 1);
      for (int i = 0; i < len; i++) begin
         wr_byte(d[i], ack);
         chk(ack, req, "write byte ack", ack, 1);
      end
      bus_stop();
   endtask

   task automatic read_check(input int len, input string req);
      logic ack;
      logic [7:0] got;
      bus_start();
      wr_byte(8'hD3, ack);
      chk(ack, "R2", "read address ack", ack, 1);
      for (int i = 0; i < len; i++) begin
         rd_byte(i != len - 1, got);
         chk(got == exp_rd(i), req, $sformatf("read byte %0d", i), got, exp_rd(i));
      end
      bus_stop();
   endtask

   task automatic check_outputs(input string req);
      repeat (4) @(posedge ref_clk);
      @(posedge ref_clk); #5;
      chk(clk_out == exp_en(), req, "outputs in high phase", clk_out, exp_en());
      @(negedge ref_clk); #5;
      chk(clk_out == '0, req, "outputs in low phase", clk_out, 0);
   endtask

   task automatic t_reset();
      chk(sda_bus == 1'b1, "R1", "sda released", sda_bus, 1);
      chk(clk_out_en == '1, "R1", "drive enables", clk_out_en, 18'h3FFFF);
      check_outputs("R1");
      read_check(4, "R1");
   endtask

   task automatic t_write_basic();
      logic [7:0] d [8] = '{8'h00, 8'h03, 8'hA5, 8'h3C, 8'h80, 8'h00, 8'h00, 8'h00};
      write_seq(d, 5, "R3");
      model[0] = 8'hA5; model[1] = 8'h3C; model[2] = 8'h80;
      check_outputs("R4");
      read_check(6, "R4");
   endtask

   task automatic t_extra_bytes();
      logic [7:0] d [8] = '{8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h40, 8'h00, 8'h00, 8'h00};
      write_seq(d, 7, "R5");
      model[0] = 8'h0F; model[1] = 8'hF0; model[2] = 8'h40;
      check_outputs("R5");
      read_check(7, "R6");
   endtask

   task automatic t_wrong_addr();
      logic ack;
      bus_start();
      wr_byte(8'hD4, ack);
      chk(!ack, "R2", "foreign address nack", ack, 0);
      wr_byte(8'h00, ack);
      chk(!ack, "R2", "byte after foreign address", ack, 0);
      bus_stop();
      read_check(4, "R2");
   endtask

   task automatic t_abort();
      logic ack, s;
      logic [7:0] got;
      bus_start();
      wr_byte(8'hD2, ack);
      wr_byte(8'h00, ack);
      wr_byte(8'h03, ack);
      for (int i = 0; i < 4; i++) bit_x(1'b0, s);
      bus_stop();
      check_outputs("R8");
      read_check(4, "R8");
      bus_start();
      wr_byte(8'hD2, ack);
      wr_byte(8'h00, ack);
      m_low = 1'b0; w(Q);
      bus_start();
      wr_byte(8'hD3, ack);
      chk(ack, "R8", "repeated start address ack", ack, 1);
      rd_byte(1'b1, got);
      chk(got == 8'h09, "R8", "count after repeated start", got, 8'h09);
      rd_byte(1'b0, got);
      chk(got == model[0], "R8", "byte 0 after repeated start", got, model[0]);
      bus_stop();
   endtask

   task automatic t_nack();
      logic ack;
      logic [7:0] got;
      bus_start();
      wr_byte(8'hD3, ack);
      rd_byte(1'b0, got);
      chk(got == 8'h09, "R7", "count byte", got, 8'h09);
      rd_byte(1'b0, got);
      chk(got == 8'hFF, "R7", "bus released after nack", got, 8'hFF);
      bus_stop();
   endtask

   task automatic t_oe();
      oe_n = 1'b0; #40;
      chk(clk_out_en == '0, "R10", "drive enables with oe_n low", clk_out_en, 0);
      oe_n = 1'b1; #40;
      chk(clk_out_en == '1, "R10", "drive enables with oe_n high", clk_out_en, 18'h3FFFF);
      read_check(4, "R10");
   endtask

   task automatic t_switch();
      logic [7:0] d0 [8] = '{8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      logic [7:0] d1 [8] = '{8'h00, 8'h03, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00};
      write_seq(d0, 5, "R9");
      model[0] = 8'h00; model[1] = 8'h00; model[2] = 8'h00;
      check_outputs("R9");
      write_seq(d1, 5, "R9");
      model[0] = 8'hFF; model[1] = 8'hFF; model[2] = 8'hFF;
      check_outputs("R9");
      chk(runt == 0, "R9", "shortened output pulses", runt, 0);
   endtask

   initial begin
      model[0] = 8'hFF; model[1] = 8'hFF; model[2] = 8'hFF;
      w(10);
      rst_n = 1'b1;
      w(10);
      t_reset();
      t_write_basic();
      t_extra_bytes();
      t_wrong_addr();
      t_abort();
      t_nack();
      t_oe();
      t_switch();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end
endmodule